// File: doc/BRIEF.md
# Dual-Channel Two-Stage Code Loader

This block is the digital front end of a two-channel 12-bit converter whose host has only an 8-bit data bus. Each channel owns a first-stage input code that the host builds in two writes: a low byte and a high nibble. Two address lines pick the channel and the piece. A separate stage of output registers holds the codes that reach the converters. An active-low update control copies the input codes of both channels into the output stage in one cycle, so the two outputs change together. When update and chip select are both asserted during a write, the output stage follows the input stage directly.

All controls are active low except the two address lines. An active-low clear empties every register asynchronously. Controls are sampled on each rising edge of the system clock. A condition that stays asserted for several edges keeps loading the bus on each of those edges.

Top module: `dual_dac_bus_if`

## Requirements
- R1: While `clrN` is low, both input codes and both output codes are zero immediately, without waiting for a clock edge and whatever the other inputs are.
- R2: An input write happens on an edge where `clrN`=1, `csN`=0, `wrN`=0 and `updN`=1. With `selPiece`=0, it loads `dataBus[7:0]` into bits 7..0 of the input code of the channel picked by `selChan` (0 = channel A, 1 = channel B).
- R3: An input write with `selPiece`=1 loads `dataBus[3:0]` into bits 11..8 of the selected input code. `dataBus[7:4]` has no effect.
- R4: An input write changes only the addressed piece of the addressed channel. Both output codes keep their values until an update.
- R5: On an edge where `updN`=0, `csN`=1 and `wrN`=0, both output codes take the full input codes of their channels. The new values appear together after that edge.
- R6: On an edge where `updN`=0, `csN`=0 and `wrN`=0, the addressed input piece is written as in R2/R3. Both output codes take the resulting input codes in the same cycle.
- R7: On an edge where `wrN`=1, or where `csN`=1 and `updN`=1, no input or output code changes.
- R8: A write, update or transparent condition held over several edges acts again on each edge, so the registers track the bus for as long as the condition lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| clrN | input | 1 | Asynchronous clear of all registers, active low |
| dataBus | input | 8 | Host data bus |
| selChan | input | 1 | Channel address: 0 = A, 1 = B |
| selPiece | input | 1 | Piece address: 0 = low byte, 1 = high nibble |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low |
| updN | input | 1 | Update control, active low |
| codeA | output | 12 | Output code of channel A |
| codeB | output | 12 | Output code of channel B |

## Verification
The input codes cannot be seen at the ports. A written piece only becomes visible after an update or in transparent mode. So the bench has to show that a write touched only its addressed piece (R4) and ignored the upper bus bits (R3) through a later update. Random runs mix partial writes to both channels with long stretches of no updates, idle cycles and writes that are blocked. After each run, a single update exposes every piece at once and the bench compares it with its own model. Directed steps add a high nibble written with junk in bus bits 7..4, transparent writes, a held update and a clear asserted between clock edges.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] loadLo;
    logic [NUM_CH-1:0] loadHi;
    logic              copyOut;
    logic              passThru;
  } loadStrobes_t;
endpackage

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_load_pkg::*;
#(
  parameter int SEL_W = 1
) (
  input  logic             clrN,
  input  logic [SEL_W-1:0] selChan,
  input  logic             selPiece,
  input  logic             csN,
  input  logic             wrN,
  input  logic             updN,
  output loadStrobes_t     strobes
);
  logic writeLive;
  logic inputEn;

  always_comb begin
    writeLive = clrN & ~wrN;
    inputEn   = writeLive & ~csN;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    always_comb begin
      strobes.loadLo[c] = inputEn & (selChan == SEL_W'(c)) & ~selPiece;
      strobes.loadHi[c] = inputEn & (selChan == SEL_W'(c)) &  selPiece;
    end
  end

  always_comb begin
    strobes.copyOut  = writeLive & ~updN &  csN;
    strobes.passThru = writeLive & ~updN & ~csN;
  end
endmodule

// File: rtl/dac_load_path.sv
module dac_load_path
  import dac_load_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input  logic                           clk,
  input  logic                           clrN,
  input  logic [BUS_W-1:0]               dataBus,
  input  loadStrobes_t                   strobes,
  output logic [NUM_CH-1:0][CODE_W-1:0]  inCode,
  output logic [NUM_CH-1:0][CODE_W-1:0]  outCode
);
  localparam int HI_W = CODE_W - BUS_W;

  logic [NUM_CH-1:0][CODE_W-1:0] inNext;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      inNext[c] = inCode[c];
      if (strobes.loadLo[c]) inNext[c][BUS_W-1:0] = dataBus;
      if (strobes.loadHi[c]) inNext[c][CODE_W-1:BUS_W] = dataBus[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge clrN) begin
      if (!clrN) begin
        inCode[c]  <= '0;
        outCode[c] <= '0;
      end else begin
        inCode[c] <= inNext[c];
        if (strobes.passThru)     outCode[c] <= inNext[c];
        else if (strobes.copyOut) outCode[c] <= inCode[c];
      end
    end
  end
endmodule

// File: rtl/dual_dac_bus_if.sv
module dual_dac_bus_if
  import dac_load_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic [BUS_W-1:0]  dataBus,
  input  logic              selChan,
  input  logic              selPiece,
  input  logic              csN,
  input  logic              wrN,
  input  logic              updN,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB
);
  loadStrobes_t                  strobes;
  logic [NUM_CH-1:0][CODE_W-1:0] inCode;
  logic [NUM_CH-1:0][CODE_W-1:0] outCode;

  dac_load_ctrl #(.SEL_W(1)) u_ctrl (
    .clrN(clrN), .selChan(selChan), .selPiece(selPiece),
    .csN(csN), .wrN(wrN), .updN(updN), .strobes(strobes)
  );

  dac_load_path #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_path (
    .clk(clk), .clrN(clrN), .dataBus(dataBus), .strobes(strobes),
    .inCode(inCode), .outCode(outCode)
  );

  assign codeA = outCode[0];
  assign codeB = outCode[1];
endmodule

// File: rtl/dual_dac_bus_if_chk.sv
module dual_dac_bus_if_chk #(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input logic                     clk,
  input logic                     clrN,
  input logic [BUS_W-1:0]         dataBus,
  input logic                     selChan,
  input logic                     selPiece,
  input logic                     csN,
  input logic                     wrN,
  input logic                     updN,
  input logic [CODE_W-1:0]        codeA,
  input logic [CODE_W-1:0]        codeB,
  input logic [1:0][CODE_W-1:0]   inCode
);
  p_clear_zero_r1: assert property (@(posedge clk)
    !clrN |-> (codeA == '0 && codeB == '0 && inCode == '0));

  p_low_byte_a_r2: assert property (@(posedge clk) disable iff (!clrN)
    (updN && !csN && !wrN && !selChan && !selPiece)
      |=> inCode[0][BUS_W-1:0] == $past(dataBus));

  p_high_nib_b_r3: assert property (@(posedge clk) disable iff (!clrN)
    (updN && !csN && !wrN && selChan && selPiece)
      |=> inCode[1][CODE_W-1:BUS_W] == $past(dataBus[CODE_W-BUS_W-1:0]));

  p_out_hold_r4: assert property (@(posedge clk) disable iff (!clrN)
    (updN && !wrN) |=> ($stable(codeA) && $stable(codeB)));

  p_copy_both_r5: assert property (@(posedge clk) disable iff (!clrN)
    (!updN && csN && !wrN) |=> (codeA == $past(inCode[0]) && codeB == $past(inCode[1])));

  p_pass_thru_r6: assert property (@(posedge clk) disable iff (!clrN)
    (!updN && !csN && !wrN) |=> (codeA == inCode[0] && codeB == inCode[1]));

  p_idle_r7: assert property (@(posedge clk) disable iff (!clrN)
    (wrN || (csN && updN)) |=> ($stable(inCode) && $stable(codeA) && $stable(codeB)));
endmodule

bind dual_dac_bus_if dual_dac_bus_if_chk #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .clrN(clrN), .dataBus(dataBus), .selChan(selChan),
  .selPiece(selPiece), .csN(csN), .wrN(wrN), .updN(updN),
  .codeA(codeA), .codeB(codeB), .inCode(inCode)
);

// File: tb/tb_dual_dac_bus_if.sv
module tb_dual_dac_bus_if;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        clrN;
  logic [7:0]  dataBus;
  logic        selChan, selPiece, csN, wrN, updN;
  logic [11:0] codeA, codeB;

  logic [11:0] mIn  [2];
  logic [11:0] mOut [2];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_bus_if dut (
    .clk(clk), .clrN(clrN), .dataBus(dataBus), .selChan(selChan),
    .selPiece(selPiece), .csN(csN), .wrN(wrN), .updN(updN),
    .codeA(codeA), .codeB(codeB)
  );

  function automatic logic [11:0] nextIn(logic [11:0] cur, int ch);
    logic [11:0] n = cur;
    if (clrN && !csN && !wrN && (selChan == ch[0])) begin
      if (selPiece) n[11:8] = dataBus[3:0];
      else          n[7:0]  = dataBus;
    end
    return n;
  endfunction

  task automatic modelEdge();
    logic [11:0] n0, n1;
    n0 = nextIn(mIn[0], 0);
    n1 = nextIn(mIn[1], 1);
    if (clrN && !wrN && !updN && !csN) begin
      mOut[0] = n0; mOut[1] = n1;
    end else if (clrN && !wrN && !updN && csN) begin
      mOut[0] = mIn[0]; mOut[1] = mIn[1];
    end
    mIn[0] = n0; mIn[1] = n1;
  endtask

  task automatic check(string tag, logic [11:0] gotA, logic [11:0] gotB,
                       logic [11:0] expA, logic [11:0] expB);
    checks++;
    if (gotA !== expA || gotB !== expB) begin
      fails++;
      $display("FAIL %s: codeA=%h codeB=%h expected codeA=%h codeB=%h",
               tag, gotA, gotB, expA, expB);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, compare at the next falling edge.
  task automatic step(string tag, logic [7:0] d, logic ch, logic pc,
                      logic cs, logic wr, logic upd);
    dataBus = d; selChan = ch; selPiece = pc; csN = cs; wrN = wr; updN = upd;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(tag, codeA, codeB, mOut[0], mOut[1]);
  endtask

  task automatic writePiece(string tag, logic ch, logic pc, logic [7:0] d);
    step(tag, d, ch, pc, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic update(string tag);
    step(tag, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    clrN = 1'b0; dataBus = '0; selChan = 0; selPiece = 0;
    csN = 1; wrN = 1; updN = 1;
    mIn[0] = '0; mIn[1] = '0; mOut[0] = '0; mOut[1] = '0;
    repeat (2) @(negedge clk);
    check("R1 reset", codeA, codeB, 12'h000, 12'h000);
    clrN = 1'b1;
    @(negedge clk);

    // R2/R3/R4: build codes piece by piece, outputs must not move
    writePiece("R2 lowA", 0, 0, 8'h5A);
    writePiece("R3 hiA junk upper bits", 0, 1, 8'hF3);
    writePiece("R2 lowB", 1, 0, 8'hC7);
    writePiece("R3 hiB", 1, 1, 8'h0E);
    check("R4 outputs held before update", codeA, codeB, 12'h000, 12'h000);
    update("R5 copy both");
    check("R5 values", codeA, codeB, 12'h35A, 12'hEC7);

    // R4: single piece changes, other pieces kept
    writePiece("R4 lowA only", 0, 0, 8'h11);
    update("R4 update");
    check("R4 other pieces kept", codeA, codeB, 12'h311, 12'hEC7);

    // R7: blocked writes
    step("R7 wr high", 8'hFF, 0, 0, 1'b0, 1'b1, 1'b1);
    step("R7 cs and upd high", 8'hFF, 1, 1, 1'b1, 1'b0, 1'b1);
    step("R7 wr high with upd", 8'hFF, 1, 0, 1'b1, 1'b1, 1'b0);
    update("R7 reveal inputs");
    check("R7 nothing moved", codeA, codeB, 12'h311, 12'hEC7);

    // R6: transparent write shows at once
    step("R6 transparent lowB", 8'h42, 1, 0, 1'b0, 1'b0, 1'b0);
    check("R6 value", codeA, codeB, 12'h311, 12'hE42);
    step("R6 transparent hiA", 8'hA9, 0, 1, 1'b0, 1'b0, 1'b0);
    check("R6 value hi", codeA, codeB, 12'h911, 12'hE42);

    // R8: held write tracks bus each edge, held update follows
    writePiece("R8 held write 1", 0, 0, 8'h01);
    writePiece("R8 held write 2", 0, 0, 8'h02);
    step("R8 held update 1", 8'h77, 0, 0, 1'b1, 1'b0, 1'b0);
    step("R8 held update 2", 8'h77, 0, 0, 1'b1, 1'b0, 1'b0);
    check("R8 tracked last value", codeA, codeB, 12'h902, 12'hE42);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      d  = 8'($urandom);
      if (op < 5)       writePiece("R2 R3 random write", 1'($urandom), 1'($urandom), d);
      else if (op < 7)  step("R7 random idle", d, 1'($urandom), 1'($urandom),
                             1'b1, 1'($urandom), 1'b1);
      else if (op < 8)  step("R7 random wr high", d, 1'($urandom), 1'($urandom),
                             1'($urandom), 1'b1, 1'($urandom));
      else if (op < 9)  update("R5 random update");
      else              step("R6 random transparent", d, 1'($urandom), 1'($urandom),
                             1'b0, 1'b0, 1'b0);
    end
    update("R5 final reveal");

    // R1: clear between edges acts at once
    #2;
    clrN = 1'b0;
    #1;
    check("R1 async clear", codeA, codeB, 12'h000, 12'h000);
    mIn[0] = '0; mIn[1] = '0; mOut[0] = '0; mOut[1] = '0;
    @(negedge clk);
    clrN = 1'b1;
    update("R1 inputs cleared");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule